// File: doc/BRIEF.md
# Prefetch Way-Lockout Victim Selector

This block chooses the way to fill when a 16-way set-associative data cache misses. Each miss comes with a request-type code, either a demand access or one of four prefetch hints. It also carries the valid bits of the addressed set. The block answers one cycle later in one of two ways. It may grant a one-hot victim way. For prefetches it may instead report that the request is dropped.

A 64-bit lockout register holds one 16-bit way mask for each prefetch hint. A set mask bit bars that way from being allocated or replaced by a prefetch of that hint. This keeps speculative fills out of part of the cache. If a mask bars every way, that hint type is switched off: its misses are dropped without allocating anything. Demand misses do not look at the masks.

Among the permitted ways, an invalid way is taken first. When every permitted way is valid, a round-robin pointer spreads the replacements across the set.

Top module: `pf_victim_sel`

## Requirements
- R1: The lockout register is loaded as a whole from `lock_wdata` when `lock_we` is high. Its fields are: bits 15:0 for the NTA hint, bits 31:16 for T0, bits 47:32 for T1 and bits 63:48 for T2. A request in the same cycle as a write still sees the previous masks.
- R2: After reset all four masks are zero, so every prefetch hint may use every way.
- R3: A granted prefetch never selects a way whose bit is set in the mask of its hint.
- R4: When the mask of a prefetch's hint has all 16 bits set, the response is a drop. There is no grant, the victim is zero, and the round-robin pointer does not move.
- R5: Demand misses ignore all lockout masks and are always granted.
- R6: If any permitted way is invalid, the victim is the lowest-numbered permitted invalid way.
- R7: If all permitted ways are valid, the victim is the first permitted way at or after the round-robin pointer, searching upward and wrapping from way 15 to way 0. After every grant the pointer becomes the victim index plus one, modulo 16. It resets to 0.
- R8: The response comes on the cycle after `req_valid`. `grant` and `drop` are never high together, and exactly one of them is high for a single cycle per request. `victim_oh` is one-hot while `grant` is high and zero otherwise.
- R9: The type codes are 0 demand, 1 NTA, 2 T0, 3 T1 and 4 T2. Codes 5 to 7 are handled as demand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_we | input | 1 | Write strobe for the lockout register |
| lock_wdata | input | 64 | New lockout masks, four 16-bit fields |
| req_valid | input | 1 | Miss request present |
| req_kind | input | 3 | Request type code |
| way_valid | input | 16 | Valid bits of the addressed set |
| victim_oh | output | 16 | Registered one-hot victim way |
| grant | output | 1 | Allocation granted, one cycle |
| drop | output | 1 | Prefetch dropped, one cycle |

## Verification
Some properties are checked by the assertions on every cycle:
- grant and drop are exclusive, and the victim is one-hot only on a grant;
- each request gets exactly one response one cycle later;
- a granted prefetch avoids its masked ways;
- a fully masked hint drops;
- demand misses always get a grant;
- a permitted invalid way is always preferred over a valid one.

Other behaviour only the bench's scenarios can show, because it needs history:
- which invalid way is chosen;
- the round-robin order and its wrap;
- the pointer staying put after a drop;
- the field layout of the register;
- the old masks being used when a write coincides with a request.

// File: rtl/pfv_pkg.sv
package pfv_pkg;
  localparam int NUM_HINTS = 4;

  typedef enum logic [2:0] {
    KIND_DEMAND = 3'd0,
    KIND_NTA    = 3'd1,
    KIND_T0     = 3'd2,
    KIND_T1     = 3'd3,
    KIND_T2     = 3'd4
  } req_kind_e;

  function automatic logic kind_is_prefetch(input logic [2:0] k);
    return (k >= 3'(KIND_NTA)) && (k <= 3'(KIND_T2));
  endfunction

  // field slot of a prefetch hint inside the lockout register
  function automatic logic [1:0] kind_slot(input logic [2:0] k);
    logic [2:0] s;
    s = k - 3'd1;
    return s[1:0];
  endfunction
endpackage

// File: rtl/pfv_lock_reg.sv
module pfv_lock_reg
  import pfv_pkg::*;
#(
  parameter int NWAYS = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [NWAYS*NUM_HINTS-1:0] wr_data,
  input  logic [2:0]                 kind,
  output logic [NWAYS-1:0]           sel_mask
);
  logic [NWAYS-1:0] field_q [NUM_HINTS];

  for (genvar h = 0; h < NUM_HINTS; h++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)     field_q[h] <= '0;
      else if (wr_en) field_q[h] <= wr_data[h*NWAYS +: NWAYS];
    end
  end

  always_comb begin
    sel_mask = '0;
    if (kind_is_prefetch(kind)) sel_mask = field_q[kind_slot(kind)];
  end
endmodule

// File: rtl/pfv_pick.sv
module pfv_pick #(
  parameter int NWAYS = 16,
  localparam int PTRW = $clog2(NWAYS)
) (
  input  logic [NWAYS-1:0] allow,
  input  logic [NWAYS-1:0] way_valid,
  input  logic [PTRW-1:0]  rr_ptr,
  output logic             pick_ok,
  output logic [PTRW-1:0]  pick_idx,
  output logic [NWAYS-1:0] pick_oh
);
  function automatic logic [PTRW-1:0] lowest_idx(input logic [NWAYS-1:0] v);
    logic [PTRW-1:0] r;
    r = '0;
    for (int i = NWAYS - 1; i >= 0; i--)
      if (v[i]) r = PTRW'(i);
    return r;
  endfunction

  function automatic logic [PTRW-1:0] next_from(input logic [NWAYS-1:0] v,
                                                input logic [PTRW-1:0] s);
    logic [PTRW-1:0] r;
    logic [PTRW-1:0] c;
    logic hit;
    r   = s;
    hit = 1'b0;
    for (int k = 0; k < NWAYS; k++) begin
      c = s + PTRW'(k);
      if (v[c] && !hit) begin
        r   = c;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  logic [NWAYS-1:0] empty_ok;
  assign empty_ok = allow & ~way_valid;
  assign pick_ok  = |allow;

  always_comb begin
    if (|empty_ok) pick_idx = lowest_idx(empty_ok);
    else           pick_idx = next_from(allow, rr_ptr);
  end

  for (genvar i = 0; i < NWAYS; i++) begin : g_oh
    assign pick_oh[i] = pick_ok && (pick_idx == PTRW'(i));
  end
endmodule

// File: rtl/pfv_rr_ptr.sv
module pfv_rr_ptr #(
  parameter int NWAYS = 16,
  localparam int PTRW = $clog2(NWAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [PTRW-1:0] adv_idx,
  output logic [PTRW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= adv_idx + PTRW'(1);
  end
endmodule

// File: rtl/pf_victim_sel.sv
module pf_victim_sel
  import pfv_pkg::*;
#(
  parameter int NWAYS = 16,
  localparam int PTRW = $clog2(NWAYS),
  localparam int CFGW = NWAYS * NUM_HINTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_we,
  input  logic [CFGW-1:0]  lock_wdata,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic [NWAYS-1:0] way_valid,
  output logic [NWAYS-1:0] victim_oh,
  output logic             grant,
  output logic             drop
);
  logic [NWAYS-1:0] lock_sel;
  logic [NWAYS-1:0] allow;
  logic [PTRW-1:0]  rr_ptr;
  logic             pick_ok;
  logic [PTRW-1:0]  pick_idx;
  logic [NWAYS-1:0] pick_oh;
  logic             alloc_ev;
  logic             drop_ev;

  pfv_lock_reg #(.NWAYS(NWAYS)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(lock_we), .wr_data(lock_wdata),
    .kind(req_kind), .sel_mask(lock_sel)
  );

  assign allow = ~lock_sel;

  pfv_pick #(.NWAYS(NWAYS)) u_pick (
    .allow(allow), .way_valid(way_valid), .rr_ptr(rr_ptr),
    .pick_ok(pick_ok), .pick_idx(pick_idx), .pick_oh(pick_oh)
  );

  assign alloc_ev = req_valid && pick_ok;
  assign drop_ev  = req_valid && !pick_ok;

  pfv_rr_ptr #(.NWAYS(NWAYS)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(alloc_ev), .adv_idx(pick_idx), .ptr(rr_ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim_oh <= '0;
      grant     <= 1'b0;
      drop      <= 1'b0;
    end else begin
      victim_oh <= alloc_ev ? pick_oh : '0;
      grant     <= alloc_ev;
      drop      <= drop_ev;
    end
  end
endmodule

// File: rtl/pfv_chk.sv
module pfv_chk
  import pfv_pkg::*;
#(
  parameter int NWAYS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_kind,
  input logic [NWAYS-1:0] way_valid,
  input logic [NWAYS-1:0] lock_sel,
  input logic [NWAYS-1:0] victim_oh,
  input logic             grant,
  input logic             drop
);
  // R8
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(grant && drop));
  // R8
  onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> $countones(victim_oh) == 1);
  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |-> victim_oh == '0);
  // R8
  resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant || drop));
  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(grant || drop));
  // R3
  lock_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lock_sel != '0) |=> (!grant || (victim_oh & $past(lock_sel)) == '0));
  // R4
  full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (&lock_sel)) |=> drop);
  // R5
  demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !kind_is_prefetch(req_kind)) |=> grant);
  // R6
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (|(~way_valid & ~lock_sel))) |=> (grant && (victim_oh & $past(way_valid)) == '0));
endmodule

bind pf_victim_sel pfv_chk #(.NWAYS(NWAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .way_valid(way_valid), .lock_sel(lock_sel), .victim_oh(victim_oh),
  .grant(grant), .drop(drop)
);

// File: tb/pf_victim_sel_bench.sv
module pf_victim_sel_bench;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lock_we = 1'b0;
  logic [63:0]   lock_wdata = '0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_kind = '0;
  logic [N-1:0]  way_valid = '0;
  logic [N-1:0]  victim_oh;
  logic          grant;
  logic          drop;

  always #4 clk = ~clk;

  pf_victim_sel u_pf_victim_sel (
    .clk(clk), .rst_n(rst_n), .lock_we(lock_we), .lock_wdata(lock_wdata),
    .req_valid(req_valid), .req_kind(req_kind), .way_valid(way_valid),
    .victim_oh(victim_oh), .grant(grant), .drop(drop)
  );

  typedef struct {
    bit          g;
    bit          d;
    logic [N-1:0] v;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  // bench-side model state
  logic [63:0] m_masks = '0;
  int          m_ptr = 0;

  function automatic logic [N-1:0] m_blocked(input logic [2:0] k);
    case (k)
      3'd1: return m_masks[15:0];
      3'd2: return m_masks[31:16];
      3'd3: return m_masks[47:32];
      3'd4: return m_masks[63:48];
      default: return '0;
    endcase
  endfunction

  function automatic exp_t predict(input logic [2:0] k, input logic [N-1:0] vv, input string tag);
    exp_t e;
    logic [N-1:0] ok;
    int w;
    ok = ~m_blocked(k);
    e.tag = tag;
    e.v = '0; e.g = 0; e.d = 0;
    w = -1;
    if (ok == '0) begin
      e.d = 1;
      return e;
    end
    for (int i = 0; i < N && w < 0; i++)
      if (ok[i] && !vv[i]) w = i;
    if (w < 0)
      for (int j = 0; j < N && w < 0; j++)
        if (ok[(m_ptr + j) % N]) w = (m_ptr + j) % N;
    e.g = 1;
    e.v[w] = 1'b1;
    m_ptr = (w + 1) % N;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        check(grant == e.g && drop == e.d && victim_oh == e.v, e.tag,
              $sformatf("got g=%0b d=%0b v=%h exp g=%0b d=%0b v=%h",
                        grant, drop, victim_oh, e.g, e.d, e.v));
      end else if (grant || drop) begin
        check(0, "R8", $sformatf("unexpected response g=%0b d=%0b exp none", grant, drop));
      end
    end
  end

  task automatic issue(input logic [2:0] k, input logic [N-1:0] vv, input string tag);
    @(negedge clk);
    lock_we = 1'b0;
    req_valid = 1'b1; req_kind = k; way_valid = vv;
    sb.push_back(predict(k, vv, tag));
  endtask

  task automatic write_masks(input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    lock_we = 1'b1; lock_wdata = d;
    m_masks = d;
  endtask

  task automatic issue_with_write(input logic [2:0] k, input logic [N-1:0] vv,
                                  input logic [63:0] d, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; way_valid = vv;
    lock_we = 1'b1; lock_wdata = d;
    sb.push_back(predict(k, vv, tag));
    m_masks = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0; lock_we = 1'b0;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(grant == 0 && drop == 0 && victim_oh == '0, "R8",
          $sformatf("reset outputs g=%0b d=%0b v=%h exp 0 0 0", grant, drop, victim_oh));
    rst_n = 1'b1;
    // R2: no writes yet, T2 may use way 0 and any way
    issue(3'd4, 16'h0000, "R2");
    issue(3'd1, 16'hFFFF, "R2");            // R7 rr from ptr 1 -> way1
    idle(2);
    // R6 lowest invalid
    issue(3'd0, 16'h00FF, "R6");            // way 8
    issue(3'd0, 16'hFEFF, "R6");            // way 8 again
    // R1 field layout: NTA locks ways 0-3, T0 locks low byte, T1 locks even, T2 full
    write_masks({16'hFFFF, 16'h5555, 16'h00FF, 16'h000F});
    issue(3'd1, 16'h0000, "R1");            // way 4
    issue(3'd2, 16'h0000, "R1");            // way 8
    issue(3'd3, 16'h0000, "R1");            // way 1
    issue(3'd4, 16'h0000, "R4");            // drop
    issue(3'd4, 16'hFFFF, "R4");            // drop, pointer unchanged
    issue(3'd0, 16'hFFFF, "R7");            // ptr after way1 -> 2
    // R5 demand ignores masks; R9 codes 5..7 like demand
    issue(3'd0, 16'hFFFE, "R5");            // way 0
    issue(3'd5, 16'hFFFF, "R9");
    issue(3'd7, 16'h7FFF, "R9");            // way 15
    // R3 prefetch with all valid uses rr over permitted ways only
    issue(3'd3, 16'hFFFF, "R3");
    issue(3'd3, 16'hFFFF, "R3");
    issue(3'd2, 16'hFFFF, "R3");
    // R7 wrap around
    for (int i = 0; i < 20; i++) issue(3'd0, 16'hFFFF, "R7");
    idle(1);
    // R1 same-cycle write uses old masks
    issue_with_write(3'd4, 16'h0000, 64'h0, "R1");     // old T2 full -> drop
    issue(3'd4, 16'h0000, "R1");                       // now way 0
    issue_with_write(3'd1, 16'h0000, {48'h0, 16'h00FF}, "R1"); // old NTA clear -> way 0
    issue(3'd1, 16'h0000, "R1");                       // way 8
    idle(1);
    // random mix
    for (int i = 0; i < 300; i++) begin
      if (($urandom % 8) == 0) begin
        logic [63:0] d;
        d = {$urandom, $urandom};
        if (($urandom % 3) == 0) d[16*($urandom % 4) +: 16] = 16'hFFFF;
        write_masks(d);
      end
      issue(3'($urandom % 8), 16'($urandom) | 16'($urandom), "R3");
    end
    idle(4);
    check(sb.size() == 0, "R8", $sformatf("pending %0d exp 0", sb.size()));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule